// File: doc/BRIEF.md
# Edge-Selectable Input Capture Unit

This block timestamps external events for a 32-bit timer. It has two independent capture channels. Each one takes an asynchronous input pin, brings it into the clock domain through a two-stage synchroniser, and watches the synchronised level for the edge polarity chosen by its own 2-bit mode field. When a qualifying edge is seen, the channel copies the timer's counter value, which arrives on an input port, into its capture register. It also raises its event flag.

Each flag stays set until a one is written to its bit on the clear strobe. While a flag is set and its enable bit is high, the shared interrupt line is asserted. A later edge always overwrites the capture register, whether or not the flag was cleared. If a clear and a capture arrive in the same cycle, the capture wins.

No data stream passes through the block, so it has no valid/ready handshake. The counter input, the pins, the mode word, the clear strobe and the enables are plain level signals, sampled on every rising clock edge. The capture values, flags and interrupt are plain outputs.

Top module: `edge_capture_unit`

## Requirements
- R1: After reset, both capture values are zero, both flags are zero and `irq` is low.
- R2: A channel whose mode field is 0 never captures: its capture value and its flag do not change, whatever its pin does.
- R3: Mode 1 captures only on a low-to-high transition of the synchronised pin.
- R4: Mode 2 captures only on a high-to-low transition of the synchronised pin.
- R5: Mode 3 captures on transitions in both directions.
- R6: Suppose a new pin level is first sampled at rising edge E. The capture register then holds the value that `counter_in` carried at edge E+2, and the flag is set after that same edge. Neither changes before that edge.
- R7: Channel n takes its mode from bits [2n+1:2n] of `mode_word`. The channels never affect each other.
- R8: A 1 in bit n of `flag_clr`, sampled at a clock edge, clears flag n. A 0 bit leaves its flag unchanged.
- R9: If a capture and a clear of the same channel happen at the same edge, the flag ends up set.
- R10: A new capture overwrites the capture register even while the flag is still set.
- R11: `irq` is high exactly when some channel n has its flag set and `irq_en[n]` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising-edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| counter_in | input | 32 | Current timer count to be captured |
| cap_pin | input | 2 | Asynchronous capture inputs, bit n for channel n |
| mode_word | input | 4 | Mode fields, channel n in bits [2n+1:2n]: 0 off, 1 rising, 2 falling, 3 both |
| flag_clr | input | 2 | Write-1-to-clear strobe for the flags |
| irq_en | input | 2 | Interrupt enable per channel |
| cap_vals | output | 64 | Capture registers, channel n in bits [32n+31:32n] |
| cap_flags | output | 2 | Capture event flags |
| irq | output | 1 | Interrupt request |

## Verification
The hardest case to reach is a clear strobe that lands on exactly the edge at which the synchroniser pipeline delivers a qualifying transition. The strobe has to arrive two cycles after the pin changed. The directed part of the stimulus places it there on purpose. The long random phase then produces many accidental collisions, because pins, clears and modes all change often and a bench model follows the three-register latency.

// File: rtl/ecap_pkg.sv
package ecap_pkg;
  localparam int MODE_W = 2;

  typedef enum logic [MODE_W-1:0] {
    CAP_OFF  = 2'd0,
    CAP_RISE = 2'd1,
    CAP_FALL = 2'd2,
    CAP_BOTH = 2'd3
  } cap_mode_e;
endpackage

// File: rtl/ecap_sync.sv
// Synchroniser chain for an asynchronous pin, plus one delayed copy of its output for edge detection.
module ecap_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_async,
  output logic lvl,
  output logic lvl_d
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk) begin
    if (!rst_n) chain_q[0] <= 1'b0;
    else        chain_q[0] <= pin_async;
  end

  generate
    for (genvar s = 1; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk) begin
        if (!rst_n) chain_q[s] <= 1'b0;
        else        chain_q[s] <= chain_q[s-1];
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) lvl_d <= 1'b0;
    else        lvl_d <= chain_q[STAGES-1];
  end

  assign lvl = chain_q[STAGES-1];
endmodule

// File: rtl/ecap_edge_sel.sv
// Turns a level and its delayed copy into a capture strobe, according to the mode.
module ecap_edge_sel
  import ecap_pkg::*;
(
  input  logic      lvl,
  input  logic      lvl_d,
  input  cap_mode_e mode,
  output logic      fire
);
  logic rise, fall;

  always_comb begin
    rise = lvl & ~lvl_d;
    fall = ~lvl & lvl_d;
    unique case (mode)
      CAP_RISE: fire = rise;
      CAP_FALL: fire = fall;
      CAP_BOTH: fire = rise | fall;
      default:  fire = 1'b0;
    endcase
  end
endmodule

// File: rtl/ecap_channel.sv
// One capture channel: synchroniser, edge selector, capture register and event flag.
module ecap_channel
  import ecap_pkg::*;
#(
  parameter int CW        = 32,
  parameter int SYNC_DEPTH = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pin_async,
  input  logic [MODE_W-1:0] mode_bits,
  input  logic [CW-1:0] cnt,
  input  logic          clr,
  output logic [CW-1:0] cap_q,
  output logic          flag_q
);
  logic lvl, lvl_d, fire;
  cap_mode_e mode;

  assign mode = cap_mode_e'(mode_bits);

  ecap_sync #(.STAGES(SYNC_DEPTH)) u_sync (
    .clk(clk), .rst_n(rst_n), .pin_async(pin_async), .lvl(lvl), .lvl_d(lvl_d)
  );

  ecap_edge_sel u_sel (.lvl(lvl), .lvl_d(lvl_d), .mode(mode), .fire(fire));

  always_ff @(posedge clk) begin
    if (!rst_n)    cap_q <= '0;
    else if (fire) cap_q <= cnt;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)    flag_q <= 1'b0;
    else if (fire) flag_q <= 1'b1;
    else if (clr)  flag_q <= 1'b0;
  end

  assert_off_holds_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == CAP_OFF) |=> $stable(cap_q));

  assert_rise_ignores_fall_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == CAP_RISE && $fell(lvl)) |=> $stable(cap_q));

  assert_fall_ignores_rise_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == CAP_FALL && $rose(lvl)) |=> $stable(cap_q));

  assert_clear_works_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !fire) |=> !flag_q);

  assert_capture_beats_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> flag_q);

  assert_overwrite_R10: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> (cap_q == $past(cnt)));
endmodule

// File: rtl/edge_capture_unit.sv
module edge_capture_unit
  import ecap_pkg::*;
#(
  parameter int NCH        = 2,
  parameter int CW         = 32,
  parameter int SYNC_DEPTH = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [CW-1:0]         counter_in,
  input  logic [NCH-1:0]        cap_pin,
  input  logic [NCH*MODE_W-1:0] mode_word,
  input  logic [NCH-1:0]        flag_clr,
  input  logic [NCH-1:0]        irq_en,
  output logic [NCH*CW-1:0]     cap_vals,
  output logic [NCH-1:0]        cap_flags,
  output logic                  irq
);
  generate
    for (genvar n = 0; n < NCH; n++) begin : g_ch
      ecap_channel #(.CW(CW), .SYNC_DEPTH(SYNC_DEPTH)) u_ch (
        .clk      (clk),
        .rst_n    (rst_n),
        .pin_async(cap_pin[n]),
        .mode_bits(mode_word[n*MODE_W +: MODE_W]),
        .cnt      (counter_in),
        .clr      (flag_clr[n]),
        .cap_q    (cap_vals[n*CW +: CW]),
        .flag_q   (cap_flags[n])
      );
    end
  endgenerate

  assign irq = |(cap_flags & irq_en);

  assert_irq_masked_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_en == '0) |-> !irq);

  assert_irq_needs_flag_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_flags == '0) |-> !irq);
endmodule

// File: tb/test_edge_capture_unit.sv
module test_edge_capture_unit;
  localparam int NCH = 2;
  localparam int CW  = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [CW-1:0] counter_in = '0;
  logic [1:0]    cap_pin = '0;
  logic [3:0]    mode_word = '0;
  logic [1:0]    flag_clr = '0;
  logic [1:0]    irq_en = '0;
  logic [63:0]   cap_vals;
  logic [1:0]    cap_flags;
  logic          irq;

  always #10 clk = ~clk;

  edge_capture_unit i_edge_capture_unit (
    .clk(clk), .rst_n(rst_n), .counter_in(counter_in), .cap_pin(cap_pin),
    .mode_word(mode_word), .flag_clr(flag_clr), .irq_en(irq_en),
    .cap_vals(cap_vals), .cap_flags(cap_flags), .irq(irq)
  );

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;
  string tag = "R1";
  logic [CW-1:0] cyc = '0;

  // bench model state
  logic [1:0]    m_s1 = '0, m_s2 = '0, m_pv = '0, m_flag = '0;
  logic [CW-1:0] m_cap [2];

  function automatic bit fires(logic s2, logic pv, logic [1:0] md);
    case (md)
      2'd1: return s2 & ~pv;
      2'd2: return ~s2 & pv;
      2'd3: return s2 ^ pv;
      default: return 1'b0;
    endcase
  endfunction

  task automatic check(string t, logic [CW-1:0] act, logic [CW-1:0] exp_v, string what);
    n_chk++;
    if (act !== exp_v) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", t, what, act, exp_v);
    end
  endtask

  task automatic compare_all();
    for (int c = 0; c < NCH; c++) begin
      check(tag, cap_vals[c*CW +: CW], m_cap[c], $sformatf("cap%0d", c));
      check(tag, {31'd0, cap_flags[c]}, {31'd0, m_flag[c]}, $sformatf("flag%0d", c));
    end
    check((tag == "R1") ? "R1" : "R11", {31'd0, irq}, {31'd0, |(m_flag & irq_en)}, "irq");
  endtask

  // One clock: update the model for the edge with the applied inputs, then compare at negedge.
  task automatic step();
    @(posedge clk);
    for (int c = 0; c < NCH; c++) begin
      if (fires(m_s2[c], m_pv[c], mode_word[2*c +: 2])) begin
        m_cap[c]  = counter_in;
        m_flag[c] = 1'b1;
      end else if (flag_clr[c]) begin
        m_flag[c] = 1'b0;
      end
    end
    m_pv = m_s2; m_s2 = m_s1; m_s1 = cap_pin;
    @(negedge clk);
    compare_all();
    cyc = cyc + 1;
    counter_in = cyc * 32'h9E37 + 32'h1000;
    flag_clr = '0;
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(20 * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    logic [CW-1:0] v;
    void'($urandom(32'd20240611));
    m_cap[0] = '0; m_cap[1] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    irq_en = 2'b11;
    // R1: reset state
    tag = "R1"; compare_all();

    // R2: mode off ignores pin toggles
    tag = "R2"; mode_word = 4'b0000;
    for (int k = 0; k < 12; k++) begin cap_pin = ~cap_pin; step(); end
    cap_pin = '0; repeat (4) step();

    // R3: rising only on channel 0, off on channel 1 (R7 separation)
    tag = "R3"; mode_word = 4'b0001;
    cap_pin = 2'b11; repeat (4) step();
    cap_pin = 2'b00; repeat (4) step();

    // R4: falling only
    tag = "R4"; mode_word = 4'b0010; flag_clr = 2'b11; step();
    cap_pin = 2'b01; repeat (4) step();
    cap_pin = 2'b00; repeat (4) step();

    // R5: both edges
    tag = "R5"; mode_word = 4'b0011;
    cap_pin = 2'b01; repeat (4) step();
    cap_pin = 2'b00; repeat (4) step();

    // R7: channel 1 rising, channel 0 off; field at bits [3:2]
    tag = "R7"; mode_word = 4'b0100; flag_clr = 2'b11; step();
    cap_pin = 2'b11; repeat (4) step();
    cap_pin = 2'b00; repeat (4) step();

    // R6: explicit latency check on channel 0 in both-edge mode
    tag = "R6"; mode_word = 4'b1111; flag_clr = 2'b11; step();
    cap_pin = 2'b01;
    step(); v = counter_in;                       // E: first sample done; value at E+1 applied now
    check("R6", {31'd0, cap_flags[0]}, 32'd0, "flag0 after E");
    step(); v = counter_in;                       // value applied for E+2
    check("R6", {31'd0, cap_flags[0]}, 32'd0, "flag0 after E+1");
    step();
    check("R6", cap_vals[31:0], v, "cap0 after E+2");
    check("R6", {31'd0, cap_flags[0]}, 32'd1, "flag0 after E+2");

    // R10: overwrite while flag still set
    tag = "R10"; cap_pin = 2'b00; step(); step(); v = counter_in; step();
    check("R10", cap_vals[31:0], v, "cap0 overwritten");

    // R9: clear lands on the capture edge
    tag = "R9"; cap_pin = 2'b01; step(); step(); flag_clr = 2'b01; step();
    check("R9", {31'd0, cap_flags[0]}, 32'd1, "flag0 kept");

    // R8: clear alone, then a 0 bit leaves the other flag
    tag = "R8"; flag_clr = 2'b01; step();
    check("R8", {31'd0, cap_flags[0]}, 32'd0, "flag0 cleared");
    repeat (3) step();

    // random phase
    tag = "R11";
    for (int p = 0; p < 60; p++) begin
      mode_word = 4'($urandom);
      irq_en = 2'($urandom);
      for (int k = 0; k < 50; k++) begin
        if ($urandom % 4 == 0) cap_pin[0] = ~cap_pin[0];
        if ($urandom % 5 == 0) cap_pin[1] = ~cap_pin[1];
        if ($urandom % 6 == 0) flag_clr = 2'($urandom);
        step();
      end
    end
    summary();
  end
endmodule